// File: doc/BRIEF.md
# Page-Hashed Compression Location Predictor

In a memory controller that packs pairs or quads of neighbouring cache lines into one storage slot, a line may live in its own slot (home) or in an alternate slot of its four-line group. This block guesses which of the two candidate slots a read should try first. It relies on the fact that lines on one page tend to compress to the same degree. The page number of the request is folded by XOR into the index of a small table of 2-bit entries. Each entry holds the last compression status seen for the pages that map to it.

A lookup is combinational. The caller supplies a page number and the line's position within its group. The block returns the slot to probe first, a flag that says whether that slot is the alternate one, and the decoded status it used. Once the real layout of a group is known, the caller presents the page and the observed status on the training port, and the entry changes on the following clock edge. Sequencing the second probe, accessing memory and decompressing are left to the surrounding logic.

Top module: `loc_predictor`

## Requirements
- R1: After reset every table entry holds uncompressed. Every lookup then chooses the home slot: pred_slot equals lk_line and pred_alt is 0.
- R2: The table index is the XOR of the page number cut into IDX_W-bit chunks, with the top chunk zero-padded. Pages whose folds are equal share one entry, for example pages 0x0102 and 0x0003.
- R3: Line 0 of a group always gets slot 0 with pred_alt 0, whatever the entry holds.
- R4: For line 1, status 2:1 (code 01) or 4:1 (code 10) gives slot 0 with pred_alt 1. Any other code gives slot 1 with pred_alt 0.
- R5: For line 2, status 4:1 (code 10) gives slot 0 with pred_alt 1. Any other code gives slot 2 with pred_alt 0.
- R6: For line 3, status 2:1 or 4:1 gives slot 2 with pred_alt 1. Any other code gives slot 3 with pred_alt 0.
- R7: Code 11 is never reported. An entry holding 11 behaves as uncompressed: pred_status is 00 and the home slot is chosen.
- R8: A training write with tr_valid high stores tr_status in the hashed entry at the next rising edge. A lookup of the same entry in the cycle of the write still returns the old value.
- R9: A training write leaves every other entry unchanged.
- R10: pred_status reports the decoded status of the looked-up entry: 00 uncompressed, 01 for 2:1, 10 for 4:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_page | input | PAGE_W (28) | Page number of the read being predicted |
| lk_line | input | 2 | Position of the line within its group of four |
| pred_slot | output | 2 | Slot to probe first |
| pred_alt | output | 1 | 1 when the first probe goes to the alternate slot |
| pred_status | output | 2 | Decoded status used for the prediction |
| tr_valid | input | 1 | Training write strobe |
| tr_page | input | PAGE_W (28) | Page number whose observed status is being recorded |
| tr_status | input | 2 | Observed status code |

## Verification
The hardest case to reach is a lookup and a training write to the same entry in the same cycle. The bench has to show that the lookup returns the stale value and that the new value appears exactly one edge later. To get there, the bench drives the lookup and the training port with the same page during the cycle of the write. It samples the outputs before the edge and again after it. Hash aliasing is reached in a similar way: the bench trains one page and then reads a different page whose chunks fold to the same index. It also reads a neighbouring index to confirm that that entry was not touched.

// File: rtl/loc_pred_pkg.sv
package loc_pred_pkg;

  typedef enum logic [1:0] {
    ST_RAW   = 2'b00,
    ST_HALF  = 2'b01,
    ST_QUART = 2'b10,
    ST_SPARE = 2'b11
  } cstat_e;

  // Map the spare code onto uncompressed
  function automatic cstat_e decode_stat(input logic [1:0] code);
    cstat_e r;
    case (code)
      2'b01:   r = ST_HALF;
      2'b10:   r = ST_QUART;
      default: r = ST_RAW;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lp_fold_hash.sv
module lp_fold_hash #(
  parameter int PAGE_W = 28,
  parameter int IDX_W  = 8
) (
  input  logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  localparam int CHUNKS = (PAGE_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [CHUNKS+1];

  assign padded = PAD_W'(page);
  assign acc[0] = '0;

  for (genvar k = 0; k < CHUNKS; k++) begin : g_fold
    assign acc[k+1] = acc[k] ^ padded[k*IDX_W +: IDX_W];
  end

  assign idx = acc[CHUNKS];
endmodule

// File: rtl/lp_stat_table.sv
module lp_stat_table #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_code,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_code
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] tab_q [DEPTH];
  logic [1:0] tab_d [DEPTH];
  logic       tab_en [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      tab_en[i] = wr_en && (wr_idx == IDX_W'(i));
      tab_d[i]  = wr_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_q[i] <= 2'b00;
      end else if (tab_en[i]) begin
        tab_q[i] <= tab_d[i];
      end
    end

    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(tab_q[i])); // R9
  end

  assign rd_code = tab_q[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tab_q[$past(wr_idx)] == $past(wr_code))); // R8
endmodule

// File: rtl/lp_slot_pick.sv
module lp_slot_pick
  import loc_pred_pkg::*;
(
  input  logic [1:0] line,
  input  logic [1:0] code,
  output logic [1:0] slot,
  output logic       alt,
  output logic [1:0] status
);
  cstat_e st;

  always_comb begin
    st   = decode_stat(code);
    slot = line;
    alt  = 1'b0;
    case (line)
      2'd1: if (st == ST_HALF || st == ST_QUART) begin slot = 2'd0; alt = 1'b1; end
      2'd2: if (st == ST_QUART)                  begin slot = 2'd0; alt = 1'b1; end
      2'd3: if (st == ST_HALF || st == ST_QUART) begin slot = 2'd2; alt = 1'b1; end
      default: ;
    endcase
    status = st;
  end
endmodule

// File: rtl/loc_predictor.sv
module loc_predictor #(
  parameter int ADDR_W     = 40,
  parameter int PAGE_OFF_W = 12,
  parameter int IDX_W      = 8,
  localparam int PAGE_W    = ADDR_W - PAGE_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic [1:0]        lk_line,
  output logic [1:0]        pred_slot,
  output logic              pred_alt,
  output logic [1:0]        pred_status,
  input  logic              tr_valid,
  input  logic [PAGE_W-1:0] tr_page,
  input  logic [1:0]        tr_status
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] tr_idx;
  logic [1:0]       lk_code;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  lp_fold_hash #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_hash_lk (
    .page(lk_page), .idx(lk_idx)
  );

  lp_fold_hash #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_hash_tr (
    .page(tr_page), .idx(tr_idx)
  );

  lp_stat_table #(.IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_idx (lk_idx),
    .rd_code(lk_code),
    .wr_en  (tr_valid),
    .wr_idx (tr_idx),
    .wr_code(tr_status)
  );

  lp_slot_pick u_pick (
    .line  (lk_line),
    .code  (lk_code),
    .slot  (pred_slot),
    .alt   (pred_alt),
    .status(pred_status)
  );

  AST_LINE0_HOME: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lk_line == 2'd0) |-> (pred_slot == 2'd0 && !pred_alt)); // R3
  AST_ALT_TARGET: assert property (@(posedge clk) disable iff (!rst_int_n)
    pred_alt |-> (pred_slot == 2'd0 || pred_slot == 2'd2)); // R4
  AST_NO_SPARE: assert property (@(posedge clk) disable iff (!rst_int_n)
    pred_status != 2'b11); // R7
  AST_HOME_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pred_alt |-> (pred_slot == lk_line)); // R1
endmodule

// File: tb/loc_predictor_test.sv
module loc_predictor_test;
  localparam int PAGE_W = 28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PAGE_W-1:0] lk_page = '0;
  logic [1:0]        lk_line = '0;
  logic [1:0]        pred_slot;
  logic              pred_alt;
  logic [1:0]        pred_status;
  logic              tr_valid = 1'b0;
  logic [PAGE_W-1:0] tr_page = '0;
  logic [1:0]        tr_status = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  loc_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_page(lk_page), .lk_line(lk_line),
    .pred_slot(pred_slot), .pred_alt(pred_alt), .pred_status(pred_status),
    .tr_valid(tr_valid), .tr_page(tr_page), .tr_status(tr_status)
  );

  // {page[15:0], line, trained status, expected slot, expected alt}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {16'h0010, 2'd1, 2'b01, 2'd0, 1'b1},   // R4
    {16'h0011, 2'd1, 2'b00, 2'd1, 1'b0},   // R4
    {16'h0012, 2'd1, 2'b10, 2'd0, 1'b1},   // R4
    {16'h0013, 2'd2, 2'b01, 2'd2, 1'b0},   // R5
    {16'h0014, 2'd2, 2'b10, 2'd0, 1'b1},   // R5
    {16'h0015, 2'd2, 2'b00, 2'd2, 1'b0},   // R5
    {16'h0016, 2'd3, 2'b00, 2'd3, 1'b0},   // R6
    {16'h0017, 2'd3, 2'b01, 2'd2, 1'b1},   // R6
    {16'h0018, 2'd3, 2'b10, 2'd2, 1'b1},   // R6
    {16'h0019, 2'd0, 2'b10, 2'd0, 1'b0},   // R3
    {16'h001A, 2'd1, 2'b11, 2'd1, 1'b0},   // R7
    {16'h001B, 2'd3, 2'b11, 2'd3, 1'b0}    // R7
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [PAGE_W-1:0] p, input logic [1:0] l);
    lk_page = p;
    lk_line = l;
    #1;
  endtask

  task automatic train(input logic [PAGE_W-1:0] p, input logic [1:0] s);
    tr_valid  = 1'b1;
    tr_page   = p;
    tr_status = s;
    @(negedge clk);
    tr_valid  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, every line goes home
    for (int l = 0; l < 4; l++) begin
      look(28'h00ABCDE, 2'(l));
      check("R1 slot", {2'b0, pred_slot}, 4'(l));
      check("R1 alt", {3'b0, pred_alt}, 4'd0);
      check("R10 status", {2'b0, pred_status}, 4'd0);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [1:0] exp_st;
      @(negedge clk);
      train(28'(VEC[v][22:7]), VEC[v][4:3]);
      look(28'(VEC[v][22:7]), VEC[v][6:5]);
      exp_st = (VEC[v][4:3] == 2'b11) ? 2'b00 : VEC[v][4:3];
      check("R4-6 slot (vector)", {2'b0, pred_slot}, {2'b0, VEC[v][2:1]});
      check("R4-6 alt (vector)", {3'b0, pred_alt}, {3'b0, VEC[v][0]});
      check("R10 status (vector)", {2'b0, pred_status}, {2'b0, exp_st});
    end

    // R8: a same-cycle lookup sees the old value, the new one appears after the edge
    @(negedge clk);
    tr_valid = 1'b1; tr_page = 28'h0000040; tr_status = 2'b10;
    look(28'h0000040, 2'd2);
    check("R8 old value same cycle", {2'b0, pred_slot}, 4'd2);
    @(negedge clk);
    tr_valid = 1'b0;
    #1;
    check("R8 new value next cycle", {2'b0, pred_slot}, 4'd0);
    check("R8 status updated", {2'b0, pred_status}, 4'd2);
    train(28'h0000040, 2'b00);
    look(28'h0000040, 2'd2);
    check("R8 last status wins", {2'b0, pred_slot}, 4'd2);

    // R2: hash aliasing, page 0x0102 and page 0x0003 fold to index 0x03
    train(28'h0000102, 2'b10);
    look(28'h0000003, 2'd2);
    check("R2 alias slot", {2'b0, pred_slot}, 4'd0);
    check("R2 alias alt", {3'b0, pred_alt}, 4'd1);
    look(28'h1000003, 2'd1);
    check("R2 upper chunk folds in", {2'b0, pred_slot}, 4'd1);

    // R9: a neighbouring entry stays uncompressed
    look(28'h0000002, 2'd2);
    check("R9 neighbour untouched", {2'b0, pred_slot}, 4'd2);
    look(28'h0000004, 2'd3);
    check("R9 other entry untouched", {2'b0, pred_slot}, 4'd3);

    // R3: line 0 stays home even on a 4:1 entry
    look(28'h0000003, 2'd0);
    check("R3 line0 on 4:1", {1'b0, pred_slot, pred_alt}, 4'd0);

    // R1: reset clears trained entries
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    look(28'h0000003, 2'd2);
    check("R1 cleared by reset", {2'b0, pred_slot}, 4'd2);
    look(28'h0000010, 2'd1);
    check("R1 cleared vector entry", {2'b0, pred_slot}, 4'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule